// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block sits between two W-bit buses, A and B, and can move data across in either direction. It can also keep a copy of each bus in a storage word of its own. Each direction has four controls of its own: a capture strobe, an output enable, a live/stored select and a storage word. A direction's select decides what it drives onto the far bus. Low sends the live value of the near bus. High sends the word stored from the near bus. The two output enables have opposite polarity. The A-to-B enable is active high and the B-to-A enable is active low, so the idle pair (low, high) isolates both buses.

Tri-state buses are modelled with split vectors. Each bus has an input vector, an output vector and a per-bit output-enable vector. One flag per bus tells the block whether some outside agent is driving that bus. The capture strobes and the resolved bus values pass through a two-flop synchroniser on the system clock. A storage word loads on the clock after a synchronised rising strobe edge. Loading ignores every enable and select. A keeper register per bus records the bus value whenever anything drives that bus. When both directions are enabled in live mode and every outside driver lets go, each bus is driven from the other's keeper, and the pair holds its last value.

Top module: `regx_xcvr`

## Requirements
- R1: `b_oe` is all ones exactly when `en_ab` is 1, and `a_oe` is all ones exactly when `en_ba_n` is 0. Otherwise each is all zeros. With `en_ab`=0 and `en_ba_n`=1 both buses are isolated.
- R2: With `sel_ab`=0, `b_out` carries the live A value: `a_in` when `a_ext`=1, otherwise the A keeper. With `sel_ab`=1 it carries the A storage word. `sel_ba` selects for `a_out` in the same way from B.
- R3: A rising edge on `stb_a` loads the resolved A bus value, as sampled at the first clock edge that sees the strobe high, into the A storage word. The load takes effect after the third clock edge. `stb_b` does the same for B. Enables and selects have no effect on loading.
- R4: With both selects low, one common strobe edge loads both words, each from its own bus.
- R5: With A driven from outside, B not driven from outside, `en_ab`=1 and `sel_ab`=0, one common strobe edge stores the A value in both words. The mirror case stores the B value in both words.
- R6: With both selects high, `b_out` shows the A word and `a_out` shows the B word at the same time, and both enables may be active.
- R7: With both directions enabled and both selects low, once all outside drivers are released each bus keeps the value it last carried, for as long as the configuration stays.
- R8: When the stored word and the live source of a direction are equal, that direction's output equals the value whatever its select is, including in the cycle the select changes.
- R9: While `rst_n` is low both enable vectors are zero and both storage words and both keepers are zero. Drive stays off until two clock edges after release.
- R10: With `sel_ab`=1 and `en_ab`=1 driving B from the A word, a common strobe edge loads the B word with the A word's old contents. To load B from outside in that case, the strobes must be staggered.
- R11: A strobe held high loads only once, at its rising edge. Later changes on the bus while the strobe stays high are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_ab | input | 1 | Enables drive of bus B, active high |
| en_ba_n | input | 1 | Enables drive of bus A, active low |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A word |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B word |
| stb_a | input | 1 | Capture strobe for the A storage word |
| stb_b | input | 1 | Capture strobe for the B storage word |
| a_ext | input | 1 | An outside agent drives bus A |
| a_in | input | W | Value driven on bus A from outside |
| a_out | output | W | Value the block offers to bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_ext | input | 1 | An outside agent drives bus B |
| b_in | input | W | Value driven on bus B from outside |
| b_out | output | W | Value the block offers to bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
Outputs and enables are combinational, so the bench drives inputs on the falling edge and checks them on the next falling edge. A keeper takes a new value one rising edge after its bus changes, and the bench's reference model moves its own keeper copies at that same edge. A storage word changes after the third rising edge, counted from the edge that first samples a raised strobe. The model takes the captured value at that edge and updates its copy only after three rising edges. The bench then holds each strobe low for three edges, so that every later rise is seen as a fresh edge.

// File: rtl/regx_pkg.sv
`timescale 1ns/1ps
package regx_pkg;
  localparam int unsigned DEF_W       = 8;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/regx_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser; each stage is one flop row.
module regx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;
    if (i == 0) begin : g_first
      assign q_nxt = d;
    end else begin : g_next
      assign q_nxt = g_stage[i-1].q_r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end
  end
  assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/regx_store.sv
`timescale 1ns/1ps
// Storage word with rising-edge strobe detection on a synchronised strobe.
module regx_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         cap
);
  logic         prev_q;
  logic [W-1:0] word_q;
  logic [W-1:0] word_nxt;

  assign cap = stb & ~prev_q;

  always_comb begin
    word_nxt = word_q;
    if (cap) word_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      word_q <= '0;
    end else begin
      prev_q <= stb;
      word_q <= word_nxt;
    end
  end

  assign q = word_q;
endmodule

// File: rtl/regx_keep.sv
`timescale 1ns/1ps
// Bus keeper: remembers the bus value while anything drives it.
module regx_keep #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         driven,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] keep_q;
  logic [W-1:0] keep_nxt;

  always_comb begin
    keep_nxt = keep_q;
    if (driven) keep_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= '0;
    else        keep_q <= keep_nxt;
  end

  assign q = keep_q;
endmodule

// File: rtl/regx_mux.sv
`timescale 1ns/1ps
// Live/stored source select with a consensus term, so equal sources never glitch.
module regx_mux #(
  parameter int unsigned W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] live,
  input  logic         enable,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  assign dout = (stored & {W{sel}}) | (live & {W{~sel}}) | (stored & live);
  assign oe   = {W{enable}};
endmodule

// File: rtl/regx_xcvr.sv
`timescale 1ns/1ps
module regx_xcvr
  import regx_pkg::*;
#(
  parameter int unsigned W = DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         stb_a,
  input  logic         stb_b,
  input  logic         a_ext,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic         b_ext,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  localparam int unsigned WS = W + 1;

  // Reset release synchroniser gating all drive.
  logic [1:0] run_q;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= {run_q[0], 1'b1};
  end
  assign run = run_q[1];

  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] keep_a, keep_b;
  logic [W-1:0] a_src, b_src;
  logic [W-1:0] a_bus, b_bus;
  logic [W-1:0] a_bus_s, b_bus_s;
  logic         stb_a_s, stb_b_s;
  logic         cap_a, cap_b;
  logic         a_driven, b_driven;

  // Live source seen by the far side: outside driver, else the keeper.
  assign a_src = a_ext ? a_in : keep_a;
  assign b_src = b_ext ? b_in : keep_b;

  regx_mux #(.W(W)) u_mux_ab (
    .sel(sel_ab), .stored(reg_a), .live(a_src),
    .enable(run & en_ab), .dout(b_out), .oe(b_oe)
  );
  regx_mux #(.W(W)) u_mux_ba (
    .sel(sel_ba), .stored(reg_b), .live(b_src),
    .enable(run & ~en_ba_n), .dout(a_out), .oe(a_oe)
  );

  // Resolved bus values: outside driver wins, then own drive, then keeper.
  assign a_driven = a_ext | a_oe[0];
  assign b_driven = b_ext | b_oe[0];
  assign a_bus = a_ext ? a_in : (a_oe[0] ? a_out : keep_a);
  assign b_bus = b_ext ? b_in : (b_oe[0] ? b_out : keep_b);

  regx_keep #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .driven(a_driven), .d(a_bus), .q(keep_a)
  );
  regx_keep #(.W(W)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .driven(b_driven), .d(b_bus), .q(keep_b)
  );

  regx_sync #(.W(WS), .STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .d({stb_a, a_bus}), .q({stb_a_s, a_bus_s})
  );
  regx_sync #(.W(WS), .STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .d({stb_b, b_bus}), .q({stb_b_s, b_bus_s})
  );

  regx_store #(.W(W)) u_store_a (
    .clk(clk), .rst_n(rst_n), .stb(stb_a_s), .d(a_bus_s), .q(reg_a), .cap(cap_a)
  );
  regx_store #(.W(W)) u_store_b (
    .clk(clk), .rst_n(rst_n), .stb(stb_b_s), .d(b_bus_s), .q(reg_b), .cap(cap_b)
  );
endmodule

// File: rtl/regx_chk.sv
`timescale 1ns/1ps
module regx_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         a_ext,
  input logic         b_ext,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] keep_a,
  input logic [W-1:0] keep_b,
  input logic         cap_a,
  input logic         cap_b
);
  logic loop_cfg;
  assign loop_cfg = en_ab & ~en_ba_n & ~sel_ab & ~sel_ba & ~a_ext & ~b_ext;

  p_oe_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe != '0) |-> (en_ab && b_oe == '1));
  p_oe_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe != '0) |-> (!en_ba_n && a_oe == '1));
  p_iso_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ab && en_ba_n) |-> (a_oe == '0 && b_oe == '0));

  p_load_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_a != $past(reg_a)) |-> $past(cap_a));
  p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b != $past(reg_b)) |-> $past(cap_b));

  p_both_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ab && sel_ba) |-> (b_out == reg_a && a_out == reg_b));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_cfg && $past(loop_cfg) && $past(a_out == b_out))
      |-> ($stable(a_out) && $stable(b_out)));

  p_agree_ab_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_a == (a_ext ? a_in : keep_a)) |-> (b_out == reg_a));
  p_agree_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b == (b_ext ? b_in : keep_b)) |-> (a_out == reg_b));

  always_comb begin
    if (!rst_n) begin
      p_reset_r9: assert (a_oe == '0 && b_oe == '0 && reg_a == '0 && reg_b == '0);
    end
  end

  p_once_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> !cap_a);
  p_once_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b |=> !cap_b);
endmodule

bind regx_xcvr regx_chk #(.W(W)) u_regx_chk (
  .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba_n(en_ba_n),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_ext(a_ext), .b_ext(b_ext),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe), .reg_a(reg_a), .reg_b(reg_b),
  .keep_a(keep_a), .keep_b(keep_b), .cap_a(cap_a), .cap_b(cap_b)
);

// File: tb/test_regx_xcvr.sv
`timescale 1ns/1ps
module test_regx_xcvr;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en_ab, en_ba_n, sel_ab, sel_ba, stb_a, stb_b;
  logic         a_ext, b_ext;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  always #5 clk = ~clk;

  regx_xcvr #(.W(W)) i_regx_xcvr (
    .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_a(stb_a), .stb_b(stb_b),
    .a_ext(a_ext), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_ext(b_ext), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // Reference model state
  logic [W-1:0] m_ra, m_rb, m_ka, m_kb;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [W-1:0] src_a();
    return a_ext ? a_in : m_ka;
  endfunction
  function automatic logic [W-1:0] src_b();
    return b_ext ? b_in : m_kb;
  endfunction
  function automatic logic [W-1:0] exp_b_out();
    return sel_ab ? m_ra : src_a();
  endfunction
  function automatic logic [W-1:0] exp_a_out();
    return sel_ba ? m_rb : src_b();
  endfunction
  function automatic logic [W-1:0] exp_b_oe();
    return en_ab ? '1 : '0;
  endfunction
  function automatic logic [W-1:0] exp_a_oe();
    return !en_ba_n ? '1 : '0;
  endfunction
  function automatic logic [W-1:0] bus_a();
    return a_ext ? a_in : (!en_ba_n ? exp_a_out() : m_ka);
  endfunction
  function automatic logic [W-1:0] bus_b();
    return b_ext ? b_in : (en_ab ? exp_b_out() : m_kb);
  endfunction

  task automatic tick();
    logic [W-1:0] nka, nkb;
    nka = bus_a();
    nkb = bus_b();
    @(posedge clk);
    m_ka = nka;
    m_kb = nkb;
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, a_out, exp_a_out());
    check(tag, b_out, exp_b_out());
    check("R1", a_oe, exp_a_oe());
    check("R1", b_oe, exp_b_oe());
  endtask

  // Strobe: model word updates after the third rising edge (R3).
  task automatic strobe(bit sa, bit sb, int extra);
    logic [W-1:0] ca, cb;
    stb_a = sa;
    stb_b = sb;
    ca = bus_a();
    cb = bus_b();
    tick(); tick(); tick();
    if (sa) m_ra = ca;
    if (sb) m_rb = cb;
    for (int i = 0; i < extra; i++) tick();
    stb_a = 1'b0;
    stb_b = 1'b0;
    tick(); tick(); tick();
  endtask

  task automatic set_ctl(bit eab, bit eban, bit sab, bit sba);
    en_ab = eab; en_ba_n = eban; sel_ab = sab; sel_ba = sba;
  endtask

  initial begin
    rst_n = 1'b0;
    set_ctl(1, 0, 0, 0);
    stb_a = 0; stb_b = 0; a_ext = 0; b_ext = 0; a_in = '0; b_in = '0;
    m_ra = '0; m_rb = '0; m_ka = '0; m_kb = '0;
    repeat (3) @(negedge clk);
    // R9: reset isolates both buses even with enables active
    check("R9", a_oe, '0);
    check("R9", b_oe, '0);
    rst_n = 1'b1;
    repeat (4) tick();
    sel_ab = 1; sel_ba = 1;
    @(negedge clk);
    check("R9", a_out, '0);
    check("R9", b_out, '0);

    // R1: every enable combination
    for (int c = 0; c < 4; c++) begin
      en_ab = c[0]; en_ba_n = c[1];
      tick();
      check("R1", a_oe, exp_a_oe());
      check("R1", b_oe, exp_b_oe());
    end

    // R4 with R3: common strobe, selects low, buses isolated
    set_ctl(0, 1, 0, 0);
    a_ext = 1; a_in = 8'h3C; b_ext = 1; b_in = 8'hA5;
    tick();
    strobe(1, 1, 0);
    sel_ab = 1; sel_ba = 1;
    tick();
    check("R4", b_out, 8'h3C);
    check("R4", a_out, 8'hA5);

    // R5: A drives B live, common strobe stores A value in both
    set_ctl(1, 1, 0, 0);
    a_ext = 1; a_in = 8'h5A; b_ext = 0;
    tick();
    strobe(1, 1, 0);
    set_ctl(0, 1, 1, 1);
    tick();
    check("R5", b_out, 8'h5A);
    check("R5", a_out, 8'h5A);
    // R5 mirror
    set_ctl(0, 0, 0, 0);
    b_ext = 1; b_in = 8'hC3; a_ext = 0;
    tick();
    strobe(1, 1, 0);
    set_ctl(0, 1, 1, 1);
    tick();
    check("R5", b_out, 8'hC3);
    check("R5", a_out, 8'hC3);

    // R10: stored A drives B, common strobe loads B with old A word
    set_ctl(1, 1, 1, 0);
    a_ext = 1; a_in = 8'h77; b_ext = 0;
    tick();
    strobe(1, 1, 0);
    set_ctl(0, 1, 1, 1);
    tick();
    check("R10", b_out, 8'h77);
    check("R10", a_out, 8'hC3);

    // R6: both stored, both enabled
    set_ctl(1, 0, 1, 1);
    a_ext = 0; b_ext = 0;
    tick();
    check("R6", b_out, 8'h77);
    check("R6", a_out, 8'hC3);
    check("R6", a_oe, '1);
    check("R6", b_oe, '1);

    // R7: loop hold after releasing the only outside driver
    set_ctl(1, 0, 0, 0);
    a_ext = 1; a_in = 8'h12; b_ext = 0;
    repeat (3) tick();
    a_ext = 0; a_in = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R7", a_out, 8'h12);
      check("R7", b_out, 8'h12);
    end
    // R7 mirror from bus B
    b_ext = 1; b_in = 8'h6E;
    repeat (3) tick();
    b_ext = 0; b_in = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R7", a_out, 8'h6E);
      check("R7", b_out, 8'h6E);
    end

    // R8: equal sources, select toggled every cycle
    set_ctl(1, 1, 0, 0);
    a_ext = 1; a_in = 8'h77;
    for (int i = 0; i < 6; i++) begin
      sel_ab = i[0];
      tick();
      check("R8", b_out, 8'h77);
    end

    // R11: strobe held high, bus changes later, only first value kept
    set_ctl(0, 1, 0, 0);
    a_ext = 1; a_in = 8'h81;
    tick();
    stb_a = 1;
    repeat (4) tick();
    a_in = 8'h18;
    repeat (5) tick();
    stb_a = 0;
    repeat (3) tick();
    m_ra = 8'h81;
    sel_ab = 1;
    tick();
    check("R11", b_out, 8'h81);

    // R2/R3: constrained random traffic with fixed seed
    void'($urandom(32'h1F2E3D4C));
    for (int it = 0; it < 300; it++) begin
      int unsigned r;
      r = $urandom;
      set_ctl(r[0], r[1], r[2], r[3]);
      a_ext = (r[6:4] != 0);
      b_ext = (r[9:7] != 0);
      a_in = W'($urandom);
      b_in = W'($urandom);
      tick();
      check_all("R2");
      if (r[11:10] == 2'b00) begin
        strobe(r[12], r[13] | ~r[12], 0);
        check_all("R3");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule